// File: doc/BRIEF.md
# Atomic Access Permission Checker

This block decides whether a compare-and-swap (conditional store) may go ahead. The load/store unit first translates the address. It then presents to this block, on one request strobe, the result of that translation (a fault code, or zero for success), the read and write permission bits of the page, the cache attribute of the page and the access address. It also supplies a configuration bit that says whether a data cache is present, and the 32-bit atomic policy register.

The verdict is computed combinationally and is registered, so it appears one clock after the strobe. A verdict is either a go, or a fault with an exception cause and the faulting address. Each access reports exactly one cause, checked in this order:

1. A translation fault.
2. A permission failure, reported as a store fault even when only read permission is missing.
3. The atomic policy check. It picks a 2-bit field of the policy register by cache attribute, and a field of zero marks atomics on that kind of memory as forbidden.

The translation lookup and the bus atomic operation are outside this block.

Top module: `atom_perm_check`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared to zero in that cycle.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. When `rsp_valid` is high, exactly one of `rsp_go` and `rsp_fault` is high. When `rsp_valid` is low, both are low.
- R3: A nonzero `xlate_cause` gives a fault whose cause equals that code and whose `rsp_addr` equals the request address.
- R4: A translation code of zero on a page where `perm_rd` or `perm_wr` is low gives a fault with cause `CAUSE_STORE_DENY` (default 29). No cause other than the translation code, `CAUSE_STORE_DENY` or `CAUSE_ATOMIC_ERR` is ever reported.
- R5: With `dcache_present` low, the cache attribute is treated as bypass whatever its value.
- R6: The cache attribute is encoded as follows: 0 is bypass, 1 is write-through, 2 is write-back, 3 is isolate, and 4 to 7 are other. Bypass uses policy bits [1:0], write-through uses bits [3:2] and write-back uses bits [5:4]. Policy bits 31 to 6 have no effect.
- R7: If the selected 2-bit field is zero, the result is a fault with cause `CAUSE_ATOMIC_ERR` (default 3) and the request address. If the field is nonzero, the result is a go.
- R8: The isolate attribute, with a data cache present, always gives a `CAUSE_ATOMIC_ERR` fault, whatever the policy value.
- R9: Attribute codes 4 to 7, with a data cache present, always give a go, whatever the policy value.
- R10: The causes take priority in this order: translation fault, then permission failure, then policy. A permission or translation fault suppresses the policy check. On a go, `rsp_cause` and `rsp_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle per access |
| xlate_cause | input | CAUSE_W (6) | Translation result: 0 for success, otherwise the fault cause |
| perm_rd | input | 1 | Page grants read |
| perm_wr | input | 1 | Page grants write |
| cache_attr | input | 3 | Page cache attribute (encoding in R6) |
| dcache_present | input | 1 | Configuration: a data cache exists |
| atom_ctl | input | CTL_W (32) | Atomic policy register |
| req_addr | input | ADDR_W (32) | Access address |
| rsp_valid | output | 1 | Verdict valid |
| rsp_go | output | 1 | Atomic may proceed |
| rsp_fault | output | 1 | Atomic raises an exception |
| rsp_cause | output | CAUSE_W (6) | Exception cause when faulting, else 0 |
| rsp_addr | output | ADDR_W (32) | Faulting address when faulting, else 0 |

## Verification
The assertions take for granted that the configuration bit and the policy register hold steady from the request edge until the verdict edge. The stimulus therefore changes them only at a falling edge together with a new request. The properties also treat every attribute code from 4 to 7 as "other". The vector table therefore sweeps all attribute classes, both data cache settings and policy values whose non-selected fields disagree with the selected one. Translation codes are kept distinct from both internal causes so that the reported cause shows which check fired.

// File: rtl/atom_chk_pkg.sv
// Package: shared constants for the atomic permission checker.
// Assumes a 3-bit cache attribute code and three 2-bit policy fields.
package atom_chk_pkg;
    localparam logic [2:0] ATTR_BYPASS = 3'd0;
    localparam logic [2:0] ATTR_WTHRU  = 3'd1;
    localparam logic [2:0] ATTR_WBACK  = 3'd2;
    localparam logic [2:0] ATTR_ISOL   = 3'd3;

    localparam int POL_FIELD_W = 2;
    localparam int POL_NFIELDS = 3;
    localparam int POL_BITS    = POL_FIELD_W * POL_NFIELDS;

    // Kind of policy treatment a cache attribute receives.
    typedef enum logic [1:0] {
        POL_FIELD = 2'd0,
        POL_DENY  = 2'd1,
        POL_PASS  = 2'd2
    } pol_kind_e;
endpackage

// File: rtl/atom_perm_stage.sv
// Module: translation and permission screen.
// Reports the translation code if nonzero. Otherwise it reports a store-denied
// cause when read or write permission is missing. Purely combinational.
module atom_perm_stage #(
    parameter int                   CAUSE_W          = 6,
    parameter logic [CAUSE_W-1:0]   CAUSE_STORE_DENY = 6'd29
) (
    input  logic [CAUSE_W-1:0] xlate_cause,
    input  logic               perm_rd,
    input  logic               perm_wr,
    output logic               pre_fault,
    output logic [CAUSE_W-1:0] pre_cause
);
    // Priority: translation fault first, then permission gap.
    always_comb begin
        pre_fault = 1'b0;
        pre_cause = '0;
        if (xlate_cause != '0) begin
            pre_fault = 1'b1;
            pre_cause = xlate_cause;
        end else if (!(perm_rd && perm_wr)) begin
            pre_fault = 1'b1;
            pre_cause = CAUSE_STORE_DENY;
        end
    end
endmodule

// File: rtl/atom_policy_sel.sv
// Module: atomic policy lookup.
// Maps the cache attribute to a policy field of the control register.
// The attribute is forced to bypass when no data cache exists.
// Assumes the configuration and policy inputs are stable around a request.
// The clock and reset feed only the assertions.
module atom_policy_sel
    import atom_chk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dcache_present,
    input  logic [2:0]          cache_attr,
    input  logic [POL_BITS-1:0] pol_bits,
    output logic                policy_ok
);
    logic [POL_FIELD_W-1:0] fld [POL_NFIELDS];
    logic [2:0]             eff_attr;
    pol_kind_e              kind;
    logic [1:0]             fsel;

    // Slice the policy register into its per-attribute fields.
    for (genvar g = 0; g < POL_NFIELDS; g++) begin : g_fld
        assign fld[g] = pol_bits[g*POL_FIELD_W +: POL_FIELD_W];
    end

    // Effective attribute: bypass when the data cache is absent.
    always_comb eff_attr = dcache_present ? cache_attr : ATTR_BYPASS;

    // Classify the attribute and pick its field index.
    always_comb begin
        kind = POL_PASS;
        fsel = 2'd0;
        case (eff_attr)
            ATTR_BYPASS: begin kind = POL_FIELD; fsel = 2'd0; end
            ATTR_WTHRU:  begin kind = POL_FIELD; fsel = 2'd1; end
            ATTR_WBACK:  begin kind = POL_FIELD; fsel = 2'd2; end
            ATTR_ISOL:   kind = POL_DENY;
            default:     kind = POL_PASS;
        endcase
    end

    // Verdict: a zero field or isolate forbids the atomic.
    always_comb begin
        case (kind)
            POL_FIELD: policy_ok = (fld[fsel] != '0);
            POL_DENY:  policy_ok = 1'b0;
            default:   policy_ok = 1'b1;
        endcase
    end

    // R8: isolate with a cache present always forbids.
    a_r8_isolate_denies: assert property (@(posedge clk) disable iff (!rst_n)
        (dcache_present && cache_attr == ATTR_ISOL) |-> !policy_ok);
    // R9: other attribute codes always pass.
    a_r9_other_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (dcache_present && cache_attr[2]) |-> policy_ok);
    // R5: without a cache only bits [1:0] matter.
    a_r5_no_cache_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !dcache_present |-> (policy_ok == (pol_bits[1:0] != 2'b00)));
endmodule

// File: rtl/atom_perm_check.sv
// Module: atomic access permission checker (top).
// Combines the translation/permission screen and the policy lookup, and
// registers one verdict per request strobe with one cycle of latency.
// Assumes at most one request per cycle and stable configuration inputs.
module atom_perm_check
    import atom_chk_pkg::*;
#(
    parameter int                 CAUSE_W          = 6,
    parameter int                 CTL_W            = 32,
    parameter int                 ADDR_W           = 32,
    parameter logic [CAUSE_W-1:0] CAUSE_STORE_DENY = 6'd29,
    parameter logic [CAUSE_W-1:0] CAUSE_ATOMIC_ERR = 6'd3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [CAUSE_W-1:0] xlate_cause,
    input  logic               perm_rd,
    input  logic               perm_wr,
    input  logic [2:0]         cache_attr,
    input  logic               dcache_present,
    input  logic [CTL_W-1:0]   atom_ctl,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               rsp_valid,
    output logic               rsp_go,
    output logic               rsp_fault,
    output logic [CAUSE_W-1:0] rsp_cause,
    output logic [ADDR_W-1:0]  rsp_addr
);
    logic               pre_fault;
    logic [CAUSE_W-1:0] pre_cause;
    logic               policy_ok;
    logic               nxt_fault;
    logic [CAUSE_W-1:0] nxt_cause;
    logic               unused_ctl_hi;

    // Policy bits above the three fields carry no meaning here.
    assign unused_ctl_hi = ^atom_ctl[CTL_W-1:POL_BITS];

    atom_perm_stage #(
        .CAUSE_W          (CAUSE_W),
        .CAUSE_STORE_DENY (CAUSE_STORE_DENY)
    ) u_perm (
        .xlate_cause (xlate_cause),
        .perm_rd     (perm_rd),
        .perm_wr     (perm_wr),
        .pre_fault   (pre_fault),
        .pre_cause   (pre_cause)
    );

    atom_policy_sel u_pol (
        .clk            (clk),
        .rst_n          (rst_n),
        .dcache_present (dcache_present),
        .cache_attr     (cache_attr),
        .pol_bits       (atom_ctl[POL_BITS-1:0]),
        .policy_ok      (policy_ok)
    );

    // Merge: an earlier fault suppresses the policy check.
    always_comb begin
        nxt_fault = pre_fault || !policy_ok;
        nxt_cause = pre_fault ? pre_cause
                  : (!policy_ok ? CAUSE_ATOMIC_ERR : '0);
    end

    // Verdict register, cleared when idle or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid <= 1'b0;
            rsp_go    <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_cause <= '0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= 1'b1;
            rsp_go    <= !nxt_fault;
            rsp_fault <= nxt_fault;
            rsp_cause <= nxt_cause;
            rsp_addr  <= nxt_fault ? req_addr : '0;
        end
    end

    // R2: the verdict follows the strobe by one cycle.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_go && !rsp_fault);
    // R2: exactly one verdict when valid.
    a_r2_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_go, rsp_fault}) == 1);
    // R3: a translation fault is passed through with its address.
    a_r3_xlate_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xlate_cause != '0) |=>
            (rsp_fault && rsp_cause == $past(xlate_cause) && rsp_addr == $past(req_addr)));
    // R4: a permission gap is a store fault.
    a_r4_perm_store: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xlate_cause == '0 && !(perm_rd && perm_wr)) |=>
            (rsp_fault && rsp_cause == CAUSE_STORE_DENY));
    // R10: a go carries no cause and no address.
    a_r10_go_clean: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_go |-> (rsp_cause == '0 && rsp_addr == '0));
endmodule

// File: tb/tb_atom_perm_check.sv
// Bench: a vector table walked by one loop, then directed reset and timing cases.
module tb_atom_perm_check;
    localparam logic [5:0] C_DENY = 6'd29;
    localparam logic [5:0] C_ERR  = 6'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  xlate_cause = '0;
    logic        perm_rd = 1'b0, perm_wr = 1'b0;
    logic [2:0]  cache_attr = '0;
    logic        dcache_present = 1'b0;
    logic [31:0] atom_ctl = '0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_go, rsp_fault;
    logic [5:0]  rsp_cause;
    logic [31:0] rsp_addr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    atom_perm_check dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .xlate_cause(xlate_cause), .perm_rd(perm_rd), .perm_wr(perm_wr),
        .cache_attr(cache_attr), .dcache_present(dcache_present),
        .atom_ctl(atom_ctl), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_go(rsp_go), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .rsp_addr(rsp_addr)
    );

    typedef struct packed {
        logic [5:0]  xc;
        logic        rd;
        logic        wr;
        logic [2:0]  at;
        logic        dc;
        logic [31:0] ctl;
        logic        go;
        logic [5:0]  ec;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VT [NV] = '{
        '{6'd5, 1'b1, 1'b1, 3'd0, 1'b1, 32'h0000_003F, 1'b0, 6'd5,  8'd3},  // R3
        '{6'd0, 1'b1, 1'b0, 3'd0, 1'b1, 32'h0000_003F, 1'b0, C_DENY, 8'd4}, // R4
        '{6'd0, 1'b0, 1'b1, 3'd1, 1'b1, 32'h0000_003F, 1'b0, C_DENY, 8'd4}, // R4
        '{6'd0, 1'b1, 1'b1, 3'd0, 1'b1, 32'h0000_0001, 1'b1, 6'd0,  8'd6},  // R6
        '{6'd0, 1'b1, 1'b1, 3'd0, 1'b1, 32'h0000_003C, 1'b0, C_ERR, 8'd7},  // R7
        '{6'd0, 1'b1, 1'b1, 3'd1, 1'b1, 32'h0000_0004, 1'b1, 6'd0,  8'd6},  // R6
        '{6'd0, 1'b1, 1'b1, 3'd1, 1'b1, 32'h0000_0033, 1'b0, C_ERR, 8'd7},  // R7
        '{6'd0, 1'b1, 1'b1, 3'd2, 1'b1, 32'h0000_0010, 1'b1, 6'd0,  8'd6},  // R6
        '{6'd0, 1'b1, 1'b1, 3'd2, 1'b1, 32'h0000_000F, 1'b0, C_ERR, 8'd7},  // R7
        '{6'd0, 1'b1, 1'b1, 3'd3, 1'b1, 32'h0000_003F, 1'b0, C_ERR, 8'd8},  // R8
        '{6'd0, 1'b1, 1'b1, 3'd5, 1'b1, 32'h0000_0000, 1'b1, 6'd0,  8'd9},  // R9
        '{6'd0, 1'b1, 1'b1, 3'd2, 1'b0, 32'h0000_0001, 1'b1, 6'd0,  8'd5},  // R5
        '{6'd0, 1'b1, 1'b1, 3'd3, 1'b0, 32'h0000_0002, 1'b1, 6'd0,  8'd5},  // R5
        '{6'd0, 1'b1, 1'b1, 3'd2, 1'b0, 32'h0000_0030, 1'b0, C_ERR, 8'd5},  // R5
        '{6'd7, 1'b0, 1'b1, 3'd3, 1'b1, 32'h0000_0000, 1'b0, 6'd7,  8'd10}, // R10
        '{6'd0, 1'b0, 1'b0, 3'd3, 1'b1, 32'h0000_0000, 1'b0, C_DENY, 8'd10},// R10
        '{6'd0, 1'b1, 1'b1, 3'd0, 1'b1, 32'hFFFF_FFC0, 1'b0, C_ERR, 8'd6}   // R6
    };

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Check a full verdict word {valid, go, fault, cause, addr}.
    task automatic check_rsp(input string rq, input logic v, input logic g, input logic f,
                             input logic [5:0] c, input logic [31:0] a);
        check({rq, " valid"}, {31'd0, rsp_valid}, {31'd0, v});
        check({rq, " go/fault"}, {30'd0, rsp_go, rsp_fault}, {30'd0, g, f});
        check({rq, " cause"}, {26'd0, rsp_cause}, {26'd0, c});
        check({rq, " addr"}, rsp_addr, a);
    endtask

    task automatic drive(input vec_t v, input logic [31:0] a);
        req_valid = 1'b1;
        xlate_cause = v.xc; perm_rd = v.rd; perm_wr = v.wr;
        cache_attr = v.at; dcache_present = v.dc; atom_ctl = v.ctl; req_addr = a;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: outputs cleared while in reset, even with a request present.
        drive(VT[0], 32'hDEAD_0000);
        @(negedge clk);
        check_rsp("R1 reset", 1'b0, 1'b0, 1'b0, 6'd0, 32'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk, one request per vector.
        for (int i = 0; i < NV; i++) begin
            logic [31:0] a;
            a = 32'h4000_0000 + 32'(i) * 32'h104;
            drive(VT[i], a);
            @(negedge clk);
            req_valid = 1'b0;
            check_rsp($sformatf("R%0d vec%0d", VT[i].rq, i), 1'b1, VT[i].go, !VT[i].go,
                      VT[i].go ? 6'd0 : VT[i].ec, VT[i].go ? 32'd0 : a);
        end

        // R2: no request gives no verdict.
        @(negedge clk);
        check_rsp("R2 idle", 1'b0, 1'b0, 1'b0, 6'd0, 32'd0);

        // R2: back-to-back requests each get their own verdict.
        drive(VT[4], 32'h0000_1110);
        @(negedge clk);
        check_rsp("R2 b2b first", 1'b1, 1'b0, 1'b1, C_ERR, 32'h0000_1110);
        drive(VT[3], 32'h0000_2220);
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R2 b2b second", 1'b1, 1'b1, 1'b0, 6'd0, 32'd0);
        @(negedge clk);
        check_rsp("R2 after b2b", 1'b0, 1'b0, 1'b0, 6'd0, 32'd0);

        // R1: reset asserted mid-stream clears a pending verdict.
        drive(VT[9], 32'h0000_3330);
        rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R1 mid reset", 1'b0, 1'b0, 1'b0, 6'd0, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule